// File: doc/BRIEF.md
# Delayed Transaction Admission Controller

This block sits in a bus bridge and decides what happens to each incoming request before any data moves. Postable requests (memory writes) are always taken. A non-postable request, such as a read, either becomes a delayed transaction or is answered with retry. A delayed transaction goes straight into an active slot, or waits in a pending queue that feeds the active slots in arrival order. Each request carries a tag. The tag is stored with the entry, so the slot contents and the promotion order can be seen at the ports.

A small control register holds three things. The first is a capacity mode that limits how many active and pending entries are allowed. The second is a block bit that refuses new delayed transactions. The third is a discard command. Discard throws away every logged entry, holds the prefetch engines idle and retries new delayed requests. It stays set until the queues are empty and the bus reports idle, so software can poll the bit to learn when the drain has finished. Bus signalling, data buffers and the upstream fabric are outside the block.

Top module: `dta_admit`

## Requirements
- R1: After reset the register reads all zeros (keep entries, accept delayed transactions, mode 00). Both queues are empty, and `resp_accept`, `resp_retry` and `pf_halt` are low.
- R2: A request with `req_postable` high gets `resp_accept` one cycle later and is never logged. This holds under block and under discard as well.
- R3: A non-postable request is accepted into the lowest-numbered free active slot, with its tag, if three conditions hold: the pending queue is empty, the active count is below the active capacity, and neither block nor discard is set.
- R4: Any other admissible non-postable request is accepted into the tail of the pending queue if the pending count is below the pending capacity. Otherwise it gets `resp_retry` and is not logged.
- R5: Register bits [1:0] select the capacity as active/pending: 00 gives 2/5, 01 gives 2/0, and 10 gives 1/0. The reserved code 11 behaves as 10.
- R6: While the active count is below capacity and discard is clear, the head of the pending queue moves into the lowest free active slot, one entry per cycle, in arrival order.
- R7: A strobe on `cpl_strobe[i]` frees active slot i at the next edge. A strobe on an empty slot has no effect.
- R8: While register bit 2 (block) is set, every non-postable request gets `resp_retry`.
- R9: Writing 1 to register bit 3 (discard) sets it. One edge later both queues are empty. While the bit is set, `pf_halt` is high and non-postable requests are retried.
- R10: Discard clears itself at the edge where both queues are empty and `bus_idle` is high. Writing 0 to bit 3 leaves the bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 4 | Write data: [3] discard, [2] block, [1:0] mode |
| reg_rdata | output | 4 | Current register value, same layout |
| req_valid | input | 1 | New request present this cycle |
| req_postable | input | 1 | Request is a postable write |
| req_tag | input | TAG_W | Identifier of the request |
| cpl_strobe | input | NUM_ACT | Completion, one bit per active slot |
| bus_idle | input | 1 | Bus has no transfer in progress |
| resp_accept | output | 1 | Previous cycle's request accepted |
| resp_retry | output | 1 | Previous cycle's request retried |
| act_valid | output | NUM_ACT | Occupancy of each active slot |
| act_tag | output | NUM_ACT*TAG_W | Tag held in each active slot |
| pend_count | output | clog2(NUM_PEND+1) | Entries in the pending queue |
| pf_halt | output | 1 | Prefetch engines held idle |

## Verification
Every decision on a request shows up on `resp_accept` or `resp_retry` one edge after the request is sampled. Slot occupancy, tags, pending count, a promotion and a freed slot all change at that same edge. A discard write shows on `reg_rdata` and `pf_halt` after its own edge, empties the queues at the following edge, and clears at the edge where the drain conditions first hold. The bench moves its behavioural model forward at each rising edge, using the inputs driven shortly after the previous one. It compares every output against the model at the falling edge, so each result is checked in the cycle it is due and never earlier or later.

// File: rtl/dta_pkg.sv
`timescale 1ns/1ps
package dta_pkg;
  typedef enum logic [1:0] {
    MODE_FULL   = 2'b00,
    MODE_DUAL   = 2'b01,
    MODE_SINGLE = 2'b10,
    MODE_RSVD   = 2'b11
  } dta_mode_e;

  typedef struct packed {
    logic      discard;
    logic      block;
    dta_mode_e mode;
  } dta_ctrl_t;
endpackage

// File: rtl/dta_ctrl_reg.sv
`timescale 1ns/1ps
module dta_ctrl_reg
  import dta_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  dta_ctrl_t wr_val,
  input  logic      drained,
  output dta_ctrl_t ctrl_q
);
  dta_ctrl_t ctrl_d;
  logic      ctrl_en;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_q.discard && drained) ctrl_d.discard = 1'b0;
    if (wr_en) begin
      ctrl_d.block   = wr_val.block;
      ctrl_d.mode    = wr_val.mode;
      ctrl_d.discard = ctrl_d.discard | wr_val.discard;
    end
  end

  assign ctrl_en = wr_en | (ctrl_q.discard & drained);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  // R10
  disc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.discard && !drained |=> ctrl_q.discard);
  // R9
  disc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_val.discard |=> ctrl_q.discard);
endmodule

// File: rtl/dta_pend_fifo.sv
`timescale 1ns/1ps
module dta_pend_fifo #(
  parameter  int DEPTH = 5,
  parameter  int TAG_W = 4,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  input  logic             pop,
  input  logic             flush,
  output logic [TAG_W-1:0] head_tag,
  output logic [CW-1:0]    count,
  output logic             empty
);
  logic [TAG_W-1:0] mem [DEPTH];
  logic [PW-1:0]    rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0]    cnt_d;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    if (flush) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      rd_d  = pop  ? wrap_inc(rd_q) : rd_q;
      wr_d  = push ? wrap_inc(wr_q) : wr_q;
      cnt_d = count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      count <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      count <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_q] <= push_tag;
  end

  assign head_tag = mem[rd_q];
  assign empty    = (count == '0);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |-> count < CW'(DEPTH));
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/dta_act_slots.sv
`timescale 1ns/1ps
module dta_act_slots #(
  parameter  int N     = 2,
  parameter  int TAG_W = 4,
  localparam int IW    = (N > 1) ? $clog2(N) : 1,
  localparam int CW    = $clog2(N + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [TAG_W-1:0]   set_tag,
  input  logic [N-1:0]       cpl,
  input  logic               flush,
  output logic [N-1:0]       valid,
  output logic [N*TAG_W-1:0] tags,
  output logic [CW-1:0]      used_cnt
);
  logic [TAG_W-1:0] tag_q [N];
  logic [N-1:0]     valid_d, hit;
  logic [IW-1:0]    free_idx;
  logic             has_free;

  always_comb begin
    free_idx = '0;
    has_free = 1'b0;
    used_cnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_idx = IW'(i);
        has_free = 1'b1;
      end
      used_cnt = used_cnt + CW'(valid[i]);
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      hit[i]     = set_en && (free_idx == IW'(i));
      valid_d[i] = flush ? 1'b0 : (hit[i] | (valid[i] & ~cpl[i]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= '0;
    else        valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) tag_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) if (hit[i]) tag_q[i] <= set_tag;
    end
  end

  // R3
  slot_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> has_free);

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign tags[g*TAG_W +: TAG_W] = tag_q[g];
    // R7
    cpl_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid[g] && cpl[g] |=> !valid[g]);
  end
endmodule

// File: rtl/dta_admit.sv
`timescale 1ns/1ps
module dta_admit
  import dta_pkg::*;
#(
  parameter  int NUM_ACT  = 2,
  parameter  int NUM_PEND = 5,
  parameter  int TAG_W    = 4,
  localparam int AC_W     = $clog2(NUM_ACT + 1),
  localparam int PC_W     = $clog2(NUM_PEND + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [3:0]               reg_wdata,
  output logic [3:0]               reg_rdata,
  input  logic                     req_valid,
  input  logic                     req_postable,
  input  logic [TAG_W-1:0]         req_tag,
  input  logic [NUM_ACT-1:0]       cpl_strobe,
  input  logic                     bus_idle,
  output logic                     resp_accept,
  output logic                     resp_retry,
  output logic [NUM_ACT-1:0]       act_valid,
  output logic [NUM_ACT*TAG_W-1:0] act_tag,
  output logic [PC_W-1:0]          pend_count,
  output logic                     pf_halt
);
  dta_ctrl_t        ctrl;
  logic [AC_W-1:0]  act_cnt, act_cap;
  logic [PC_W-1:0]  pend_cap;
  logic [TAG_W-1:0] head_tag, set_tag;
  logic             pend_empty, drained, np_req, open;
  logic             take_act, take_pend, promote, set_en;
  logic             acc_d, rty_d;

  dta_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_we),
    .wr_val  (dta_ctrl_t'(reg_wdata)),
    .drained (drained),
    .ctrl_q  (ctrl)
  );

  always_comb begin
    case (ctrl.mode)
      MODE_FULL: begin act_cap = AC_W'(NUM_ACT); pend_cap = PC_W'(NUM_PEND); end
      MODE_DUAL: begin act_cap = AC_W'(NUM_ACT); pend_cap = '0;              end
      default:   begin act_cap = AC_W'(1);       pend_cap = '0;              end
    endcase
  end

  assign np_req    = req_valid && !req_postable;
  assign open      = !ctrl.discard && !ctrl.block;
  assign take_act  = np_req && open && pend_empty && (act_cnt < act_cap);
  assign take_pend = np_req && open && !take_act && (pend_count < pend_cap);
  assign promote   = !ctrl.discard && !pend_empty && (act_cnt < act_cap);
  assign set_en    = take_act | promote;
  assign set_tag   = take_act ? req_tag : head_tag;
  assign acc_d     = req_valid && (req_postable || take_act || take_pend);
  assign rty_d     = np_req && !take_act && !take_pend;
  assign drained   = (act_cnt == '0) && pend_empty && bus_idle;

  dta_pend_fifo #(.DEPTH(NUM_PEND), .TAG_W(TAG_W)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (take_pend),
    .push_tag (req_tag),
    .pop      (promote),
    .flush    (ctrl.discard),
    .head_tag (head_tag),
    .count    (pend_count),
    .empty    (pend_empty)
  );

  dta_act_slots #(.N(NUM_ACT), .TAG_W(TAG_W)) u_act (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (set_en),
    .set_tag  (set_tag),
    .cpl      (cpl_strobe),
    .flush    (ctrl.discard),
    .valid    (act_valid),
    .tags     (act_tag),
    .used_cnt (act_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_accept <= 1'b0;
      resp_retry  <= 1'b0;
    end else begin
      resp_accept <= acc_d;
      resp_retry  <= rty_d;
    end
  end

  assign reg_rdata = ctrl;
  assign pf_halt   = ctrl.discard;

  // R2
  postable_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_postable |=> resp_accept && !resp_retry);
  // R8
  blk_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    np_req && reg_rdata[2] |=> resp_retry);
  // R9
  disc_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_halt |=> (act_valid == '0) && (pend_count == '0));
  // R9
  disc_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    np_req && pf_halt |=> resp_retry);
endmodule

// File: tb/tb_dta_admit.sv
`timescale 1ns/1ps
module tb_dta_admit;
  localparam int NA = 2;
  localparam int NP = 5;
  localparam int TW = 4;

  logic          clk, rst_n;
  logic          reg_we;
  logic [3:0]    reg_wdata, reg_rdata;
  logic          req_valid, req_postable;
  logic [TW-1:0] req_tag;
  logic [NA-1:0] cpl_strobe;
  logic          bus_idle;
  logic          resp_accept, resp_retry, pf_halt;
  logic [NA-1:0] act_valid;
  logic [NA*TW-1:0] act_tag;
  logic [2:0]    pend_count;

  dta_admit #(.NUM_ACT(NA), .NUM_PEND(NP), .TAG_W(TW)) dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  string cur_r = "R1";

  // behavioural reference
  bit m_av [NA];
  int m_at [NA];
  int m_pq [$];
  bit m_disc, m_blk, m_acc, m_rty;
  int m_mode;

  always @(posedge clk or negedge rst_n) begin
    int acap, pcap, acnt, fr;
    bit np, ta, tp, pr, drn;
    if (!rst_n) begin
      for (int i = 0; i < NA; i++) begin m_av[i] = 0; m_at[i] = 0; end
      m_pq.delete();
      m_disc = 0; m_blk = 0; m_mode = 0; m_acc = 0; m_rty = 0;
    end else begin
      case (m_mode)
        0:       begin acap = NA; pcap = NP; end
        1:       begin acap = NA; pcap = 0;  end
        default: begin acap = 1;  pcap = 0;  end
      endcase
      acnt = 0; fr = -1;
      for (int i = 0; i < NA; i++) begin
        if (m_av[i]) acnt++;
        else if (fr < 0) fr = i;
      end
      np  = req_valid && !req_postable;
      ta  = np && !m_disc && !m_blk && m_pq.size() == 0 && acnt < acap;
      tp  = np && !m_disc && !m_blk && !ta && m_pq.size() < pcap;
      pr  = !m_disc && m_pq.size() > 0 && acnt < acap;
      drn = acnt == 0 && m_pq.size() == 0 && bus_idle;
      m_acc = req_valid && (req_postable || ta || tp);
      m_rty = np && !ta && !tp;
      if (m_disc) begin
        for (int i = 0; i < NA; i++) m_av[i] = 0;
        m_pq.delete();
      end else begin
        for (int i = 0; i < NA; i++) if (cpl_strobe[i]) m_av[i] = 0;
        if (ta) begin m_av[fr] = 1; m_at[fr] = req_tag; end
        if (pr) begin m_av[fr] = 1; m_at[fr] = m_pq.pop_front(); end
        if (tp) m_pq.push_back(int'(req_tag));
      end
      if (m_disc && drn) m_disc = 0;
      if (reg_we) begin
        m_blk  = reg_wdata[2];
        m_mode = int'(reg_wdata[1:0]);
        if (reg_wdata[3]) m_disc = 1;
      end
    end
  end

  task automatic chk(string r, string nm, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", r, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_r, "resp_accept", int'(resp_accept), int'(m_acc));
      chk(cur_r, "resp_retry", int'(resp_retry), int'(m_rty));
      chk(cur_r, "pend_count", int'(pend_count), m_pq.size());
      chk(cur_r, "reg_rdata", int'(reg_rdata), (int'(m_disc) << 3) | (int'(m_blk) << 2) | m_mode);
      chk(cur_r, "pf_halt", int'(pf_halt), int'(m_disc));
      for (int i = 0; i < NA; i++) begin
        chk(cur_r, "act_valid", int'(act_valid[i]), int'(m_av[i]));
        if (m_av[i]) chk(cur_r, "act_tag", int'(act_tag[i*TW +: TW]), m_at[i]);
      end
    end
  end

  task automatic cyc(bit we, logic [3:0] wd, bit rv, bit rp, int tag, logic [NA-1:0] cp, bit idle);
    @(posedge clk); #2;
    reg_we = we; reg_wdata = wd; req_valid = rv; req_postable = rp;
    req_tag = TW'(tag); cpl_strobe = cp; bus_idle = idle;
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) cyc(0, 4'h0, 0, 0, 0, '0, 1);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] lf;
    rst_n = 0; reg_we = 0; reg_wdata = 0; req_valid = 0; req_postable = 0;
    req_tag = 0; cpl_strobe = 0; bus_idle = 1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R1: reset values at the ports
    chk("R1", "reset rdata", int'(reg_rdata), 0);
    chk("R1", "reset act_valid", int'(act_valid), 0);
    chk("R1", "reset pend", int'(pend_count), 0);
    chk("R1", "reset accept/retry", int'({resp_accept, resp_retry, pf_halt}), 0);

    cur_r = "R3";
    cyc(0, 0, 1, 0, 1, '0, 1); cyc(0, 0, 1, 0, 2, '0, 1); nop(1);
    cur_r = "R4";
    for (int t = 3; t <= 8; t++) cyc(0, 0, 1, 0, t, '0, 1);
    nop(1);
    cur_r = "R2";
    cyc(0, 0, 1, 1, 9, '0, 1); nop(1);
    cur_r = "R7";
    cyc(0, 0, 0, 0, 0, 2'b10, 1); nop(2);
    cur_r = "R6";
    cyc(0, 0, 0, 0, 0, 2'b11, 1); nop(2); cyc(0, 0, 0, 0, 0, 2'b01, 1); nop(2);
    cur_r = "R7";
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 2'b11, 1);
    nop(2);
    cur_r = "R5";
    cyc(1, 4'b0001, 0, 0, 0, '0, 1);
    for (int t = 1; t <= 4; t++) cyc(0, 0, 1, 0, t, '0, 1);
    cyc(0, 0, 0, 0, 0, 2'b11, 1);
    cyc(1, 4'b0010, 0, 0, 0, '0, 1);
    for (int t = 5; t <= 7; t++) cyc(0, 0, 1, 0, t, '0, 1);
    cyc(0, 0, 0, 0, 0, 2'b11, 1);
    cyc(1, 4'b0011, 0, 0, 0, '0, 1);
    for (int t = 8; t <= 10; t++) cyc(0, 0, 1, 0, t, '0, 1);
    cyc(1, 4'b0000, 0, 0, 0, 2'b11, 1); nop(2);
    cur_r = "R8";
    cyc(1, 4'b0100, 0, 0, 0, '0, 1);
    cyc(0, 0, 1, 0, 3, '0, 1); cyc(0, 0, 1, 1, 4, '0, 1);
    cyc(1, 4'b0000, 0, 0, 0, '0, 1); nop(1);
    cur_r = "R9";
    for (int t = 1; t <= 4; t++) cyc(0, 0, 1, 0, t, '0, 1);
    cyc(1, 4'b1000, 0, 0, 0, '0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, i[0], 11, '0, 0);
    cur_r = "R10";
    cyc(1, 4'b0000, 0, 0, 0, '0, 0); nop(0);
    cyc(0, 0, 0, 0, 0, '0, 0); nop(3);

    cur_r = "R6";
    lf = 32'h1ACE_B00C;
    for (int k = 0; k < 1500; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      cyc(lf[4:0] == 5'd0, {lf[7:6] == 2'b00, lf[8], lf[10:9]},
          lf[11], lf[13:12] == 2'b00, int'(lf[17:14]),
          {lf[19:18] == 2'b00, lf[21:20] == 2'b00}, lf[23:22] != 2'b00);
    end
    nop(3);
    finish_run();
  end
endmodule